// File: doc/BRIEF.md
# Bus Request and Daisy-Chain Grant Client

This block is the requesting side of a bus that arbitrates with a daisy-chained grant. It keeps five request levels and drives their request lines in parallel: four interrupt levels of rising priority and one direct-memory-access level. A host loads one request record per level. An interrupt record holds a vector, a completion tag, a register handle and a register value. A DMA record uses only the tag. Each loaded level raises its request line until the arbiter grants it.

For every level the block watches the incoming grant line. A grant on a level with nothing open is handed on, one cycle later, to the grant output that feeds devices further down the chain. A grant on a level with an open request is taken. The request line drops, the selection acknowledge rises, and the block pulses a start to the interrupt engine or to the DMA engine. The level then stays busy until that engine reports completion. At that point the stored tag is returned and the level can be loaded again. The engines themselves and the bus data cycles lie outside this block.

Top module: `busreq_client`

## Requirements
- R1: Level numbering is one-hot over five bits and is the same on `ld_idx` (as an index), `req_out`, `gnt_in` and `gnt_out`: bit 0 is interrupt level 4, bit 1 is level 5, bit 2 is level 6, bit 3 is level 7, and bit 4 is the DMA request.
- R2: A load to an idle level raises that level's `req_out` bit in the cycle after the strobe. The bit stays high until a grant is accepted on that level.
- R3: A load accepted on an interrupt level pulses `reg_wr_en` for one cycle, with the loaded handle and value, in the same cycle the request line first rises. A load on the DMA level produces no register write.
- R4: A load to a level that is pending or busy, or with an index above 4, sets `ld_err` for one cycle in the next cycle and changes no request line.
- R5: A grant on a level with no open request appears on the same bit of `gnt_out` one cycle later.
- R6: An accepted grant clears the level's request line, sets `sack`, and in the next cycle pulses `intr_start` (interrupt level, with `intr_vector` and `start_level`) or `dma_start` (DMA level). The grant is not passed on.
- R7: When several pending levels are granted in the same cycle, the DMA level wins, then level 7, 6, 5 and 4. The losers stay pending.
- R8: `sack` stays high until the grant input of the accepted level goes low. While `sack` is high, that level's grant is not passed on.
- R9: While a transfer is outstanding or `sack` is high, no grant is accepted. A grant on a pending level is then neither consumed nor passed on.
- R10: A taken level stays busy until `intr_done` (interrupt levels) or `dma_done` (DMA level) is seen. The done signal of the other engine has no effect. On completion `done_valid` pulses with the tag stored for that level, and the level accepts a new load.
- R11: A synchronous active-low reset clears all pending requests, `req_out`, `gnt_out`, `sack` and every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Host load strobe |
| ld_idx | input | 3 | Level index of the load (0..4) |
| ld_vector | input | 16 | Interrupt vector to store |
| ld_tag | input | 32 | Completion tag to store |
| ld_handle | input | 8 | Register handle for the coincident register write |
| ld_regval | input | 16 | Register value for the coincident register write |
| ld_err | output | 1 | Load rejected (one-cycle pulse) |
| req_out | output | 5 | Request lines, one per level |
| gnt_in | input | 5 | Incoming grant lines |
| gnt_out | output | 5 | Grant lines passed down the chain |
| sack | output | 1 | Selection acknowledge |
| intr_start | output | 1 | Start pulse to the interrupt engine |
| dma_start | output | 1 | Start pulse to the DMA engine |
| start_level | output | 3 | Level of the last started transfer |
| intr_vector | output | 16 | Vector handed to the interrupt engine |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_handle | output | 8 | Register handle of the write |
| reg_wr_value | output | 16 | Register value of the write |
| intr_done | input | 1 | Interrupt engine completion |
| dma_done | input | 1 | DMA engine completion |
| done_valid | output | 1 | Completion report (one-cycle pulse) |
| done_tag | output | 32 | Tag of the completed request |

## Verification
The bench builds the block with its default parameters: four interrupt levels plus the DMA level, 16-bit vectors and 32-bit tags. With five grant lines, all 32 grant patterns can be swept on an idle block. Each level can be walked through load, duplicate load, grant, acknowledge release, a done from the wrong engine and the right done. Filling all five levels at once and granting everything repeatedly covers the full priority order. Separate sequences cover a grant arriving during an outstanding transfer, out-of-range indices and a reset in mid-flight.

// File: rtl/busreq_pkg.sv
// Package: shared types for the bus request client.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package busreq_pkg;

    // Life cycle of one request level.
    typedef enum logic [1:0] {
        LV_IDLE = 2'd0,   // nothing open, accepts a load
        LV_PEND = 2'd1,   // request line raised, waiting for a grant
        LV_BUSY = 2'd2    // granted, waiting for the engine's done
    } lvl_state_e;

endpackage

// File: rtl/busreq_level.sv
// Module: one request level. It holds the level's state and its stored
// vector and completion tag.
// Assumes load_i is only raised while idle_o is high, accept_i only while
// pending_o is high, and done_i only while the level is busy.
module busreq_level
    import busreq_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             accept_i,
    input  logic             done_i,
    output logic             pending_o,
    output logic             idle_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [TAG_W-1:0] tag_o
);

    lvl_state_e       state_q;
    logic [VEC_W-1:0] vec_q;
    logic [TAG_W-1:0] tag_q;

    // Level state: idle -> pending on load, pending -> busy on grant, busy -> idle on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LV_IDLE;
        end else begin
            case (state_q)
                LV_IDLE: if (load_i)   state_q <= LV_PEND;
                LV_PEND: if (accept_i) state_q <= LV_BUSY;
                LV_BUSY: if (done_i)   state_q <= LV_IDLE;
                default:               state_q <= LV_IDLE;
            endcase
        end
    end

    // Record capture: the payload needs no reset, it is written on every accepted load.
    always_ff @(posedge clk) begin
        if (load_i) begin
            vec_q <= vec_i;
            tag_q <= tag_i;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        pending_o = (state_q == LV_PEND);
        idle_o    = (state_q == LV_IDLE);
        vec_o     = vec_q;
        tag_o     = tag_q;
    end

endmodule

// File: rtl/busreq_prio.sv
// Module: fixed-priority picker. The highest set index wins.
// Assumes N >= 1 and IDX_W wide enough to hold N-1.
module busreq_prio #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // Scan upward so that later (higher) indices override earlier ones.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (req_i[k]) begin
                grant_o    = '0;
                grant_o[k] = 1'b1;
                idx_o      = IDX_W'(k);
                any_o      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/busreq_client.sv
// Module: request side of a daisy-chained bus arbitration. It has NUM_INTR
// interrupt levels plus one DMA level at the top index.
// Assumes one transfer at a time: once a grant is taken, no further grant is
// accepted until the engine reports done and the grant input has dropped.
module busreq_client #(
    parameter int NUM_INTR = 4,
    parameter int VEC_W    = 16,
    parameter int TAG_W    = 32,
    parameter int HDL_W    = 8,
    parameter int REG_W    = 16,
    parameter int NLVL     = NUM_INTR + 1,
    parameter int IDX_W    = $clog2(NLVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [VEC_W-1:0] ld_vector,
    input  logic [TAG_W-1:0] ld_tag,
    input  logic [HDL_W-1:0] ld_handle,
    input  logic [REG_W-1:0] ld_regval,
    output logic             ld_err,
    output logic [NLVL-1:0]  req_out,
    input  logic [NLVL-1:0]  gnt_in,
    output logic [NLVL-1:0]  gnt_out,
    output logic             sack,
    output logic             intr_start,
    output logic             dma_start,
    output logic [IDX_W-1:0] start_level,
    output logic [VEC_W-1:0] intr_vector,
    output logic             reg_wr_en,
    output logic [HDL_W-1:0] reg_wr_handle,
    output logic [REG_W-1:0] reg_wr_value,
    input  logic             intr_done,
    input  logic             dma_done,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag
);

    localparam int              DMA_IDX  = NUM_INTR;
    localparam logic [IDX_W-1:0] DMA_CODE = IDX_W'(DMA_IDX);

    logic [NLVL-1:0]  load_ok;
    logic [NLVL-1:0]  pending;
    logic [NLVL-1:0]  idle;
    logic [NLVL-1:0]  cand;
    logic [NLVL-1:0]  acc_hot;
    logic [NLVL-1:0]  done_hot;
    logic [NLVL-1:0]  sack_block;
    logic [IDX_W-1:0] acc_idx;
    logic             acc_any;
    logic             done_now;
    logic [VEC_W-1:0] vec_arr [NLVL];
    logic [TAG_W-1:0] tag_arr [NLVL];

    logic             xfer_act_q;
    logic [IDX_W-1:0] act_idx_q;
    logic             sack_q;
    logic [NLVL-1:0]  gnt_out_q;
    logic             intr_start_q;
    logic             dma_start_q;
    logic [VEC_W-1:0] intr_vector_q;
    logic             reg_wr_en_q;
    logic [HDL_W-1:0] reg_wr_handle_q;
    logic [REG_W-1:0] reg_wr_value_q;
    logic             ld_err_q;
    logic             done_valid_q;
    logic [TAG_W-1:0] done_tag_q;

    // One level instance per request line, with its own load match.
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        assign load_ok[g] = ld_valid && (ld_idx == IDX_W'(g)) && idle[g];

        busreq_level #(
            .VEC_W (VEC_W),
            .TAG_W (TAG_W)
        ) u_level (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load_ok[g]),
            .vec_i     (ld_vector),
            .tag_i     (ld_tag),
            .accept_i  (acc_hot[g]),
            .done_i    (done_hot[g]),
            .pending_o (pending[g]),
            .idle_o    (idle[g]),
            .vec_o     (vec_arr[g]),
            .tag_o     (tag_arr[g])
        );
    end

    // Grant candidates: granted pending levels, gated while a transfer or sack is open.
    always_comb begin
        cand = gnt_in & pending & {NLVL{!xfer_act_q && !sack_q}};
    end

    busreq_prio #(
        .N     (NLVL),
        .IDX_W (IDX_W)
    ) u_prio (
        .req_i   (cand),
        .grant_o (acc_hot),
        .idx_o   (acc_idx),
        .any_o   (acc_any)
    );

    // Completion decode: the done signal of the engine that matches the active level.
    always_comb begin
        done_now = xfer_act_q && ((act_idx_q == DMA_CODE) ? dma_done : intr_done);
        done_hot = '0;
        if (done_now) done_hot[act_idx_q] = 1'b1;
    end

    // Pass-through block: the level held by sack keeps its grant.
    always_comb begin
        sack_block = '0;
        if (sack_q) sack_block[act_idx_q] = 1'b1;
    end

    // Transfer tracking, acknowledge and engine start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_act_q   <= 1'b0;
            act_idx_q    <= '0;
            sack_q       <= 1'b0;
            intr_start_q <= 1'b0;
            dma_start_q  <= 1'b0
            ;
        end else begin
            intr_start_q <= acc_any && (acc_idx != DMA_CODE);
            dma_start_q  <= acc_any && (acc_idx == DMA_CODE);
            if (acc_any) begin
                xfer_act_q <= 1'b1;
                act_idx_q  <= acc_idx;
                sack_q     <= 1'b1;
            end else begin
                if (done_now) xfer_act_q <= 1'b0;
                if (sack_q && !gnt_in[act_idx_q]) sack_q <= 1'b0;
            end
        end
    end

    // Vector handed to the interrupt engine, captured at grant acceptance.
    always_ff @(posedge clk) begin
        if (acc_any) intr_vector_q <= vec_arr[acc_idx];
    end

    // Registered grant pass-through for levels with nothing open.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_out_q <= '0;
        else        gnt_out_q <= gnt_in & ~pending & ~sack_block;
    end

    // Host-side strobes: coincident register write, load error and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr_en_q  <= 1'b0;
            ld_err_q     <= 1'b0;
            done_valid_q <= 1'b0;
        end else begin
            reg_wr_en_q  <= |load_ok[NUM_INTR-1:0];
            ld_err_q     <= ld_valid && !(|load_ok);
            done_valid_q <= done_now;
        end
    end

    // Payloads that travel with the host-side strobes.
    always_ff @(posedge clk) begin
        if (|load_ok[NUM_INTR-1:0]) begin
            reg_wr_handle_q <= ld_handle;
            reg_wr_value_q  <= ld_regval;
        end
        if (done_now) done_tag_q <= tag_arr[act_idx_q];
    end

    // Output wiring.
    always_comb begin
        req_out       = pending;
        gnt_out       = gnt_out_q;
        sack          = sack_q;
        intr_start    = intr_start_q;
        dma_start     = dma_start_q;
        start_level   = act_idx_q;
        intr_vector   = intr_vector_q;
        reg_wr_en     = reg_wr_en_q;
        reg_wr_handle = reg_wr_handle_q;
        reg_wr_value  = reg_wr_value_q;
        ld_err        = ld_err_q;
        done_valid    = done_valid_q;
        done_tag      = done_tag_q;
    end

endmodule

// File: rtl/busreq_client_chk.sv
// Module: property checker for busreq_client, attached with bind below.
// Assumes reset is held low for at least two clock cycles.
module busreq_client_chk #(
    parameter int NLVL  = 5,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic             ld_err,
    input logic [NLVL-1:0]  req_out,
    input logic [NLVL-1:0]  gnt_in,
    input logic [NLVL-1:0]  gnt_out,
    input logic             sack,
    input logic             intr_start,
    input logic             dma_start,
    input logic [IDX_W-1:0] start_level,
    input logic             reg_wr_en,
    input logic             intr_done,
    input logic             dma_done,
    input logic             done_valid
);

    // At most one engine is started at a time.
    assert_one_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({intr_start, dma_start}));

    // A start pulse always comes with the acknowledge raised.
    assert_start_sack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_start || dma_start) |-> sack);

    // A request line only falls when its grant is taken.
    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|($past(req_out) & ~req_out))) |-> (intr_start || dma_start));

    // A level that had its request open is never passed down the chain.
    assert_no_pass_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((gnt_out & $past(req_out)) == '0));

    // The register write coincides with a request line rising.
    assert_regwr_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_wr_en) |-> (|(req_out & ~$past(req_out))));

    // Acknowledge holds while the accepted level's grant stays high.
    assert_sack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sack && gnt_in[start_level]) |=> sack);

    // A completion report follows an engine done.
    assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && done_valid) |-> $past(intr_done || dma_done));

    // A load error follows a load strobe.
    assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ld_err) |-> $past(ld_valid));

endmodule

bind busreq_client busreq_client_chk #(
    .NLVL  (NLVL),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_err      (ld_err),
    .req_out     (req_out),
    .gnt_in      (gnt_in),
    .gnt_out     (gnt_out),
    .sack        (sack),
    .intr_start  (intr_start),
    .dma_start   (dma_start),
    .start_level (start_level),
    .reg_wr_en   (reg_wr_en),
    .intr_done   (intr_done),
    .dma_done    (dma_done),
    .done_valid  (done_valid)
);

// File: tb/tb_busreq_client.sv
`timescale 1ns/1ps
// Bench: sweeps grant patterns, levels and priority orders on the default build.
module tb_busreq_client;

    localparam int NLVL = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid;
    logic [2:0]  ld_idx;
    logic [15:0] ld_vector;
    logic [31:0] ld_tag;
    logic [7:0]  ld_handle;
    logic [15:0] ld_regval;
    logic        ld_err;
    logic [4:0]  req_out;
    logic [4:0]  gnt_in;
    logic [4:0]  gnt_out;
    logic        sack;
    logic        intr_start;
    logic        dma_start;
    logic [2:0]  start_level;
    logic [15:0] intr_vector;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_handle;
    logic [15:0] reg_wr_value;
    logic        intr_done;
    logic        dma_done;
    logic        done_valid;
    logic [31:0] done_tag;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    busreq_client dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_vector(ld_vector), .ld_tag(ld_tag), .ld_handle(ld_handle),
        .ld_regval(ld_regval), .ld_err(ld_err), .req_out(req_out),
        .gnt_in(gnt_in), .gnt_out(gnt_out), .sack(sack),
        .intr_start(intr_start), .dma_start(dma_start),
        .start_level(start_level), .intr_vector(intr_vector),
        .reg_wr_en(reg_wr_en), .reg_wr_handle(reg_wr_handle),
        .reg_wr_value(reg_wr_value), .intr_done(intr_done),
        .dma_done(dma_done), .done_valid(done_valid), .done_tag(done_tag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ld_valid = 1'b0; ld_idx = '0; ld_vector = '0; ld_tag = '0;
        ld_handle = '0; ld_regval = '0; gnt_in = '0; intr_done = 1'b0; dma_done = 1'b0;
        repeat (3) step();
        chk("R11 req_out after reset", 64'(req_out), 64'h0);
        chk("R11 gnt_out after reset", 64'(gnt_out), 64'h0);
        chk("R11 sack after reset", 64'(sack), 64'h0);
        chk("R11 strobes after reset", 64'({intr_start, dma_start, reg_wr_en, ld_err, done_valid}), 64'h0);
        rst_n = 1'b1;
        step();
    endtask

    // Load one record; returns after the edge that samples it.
    task automatic do_load(input int idx, input logic [15:0] v, input logic [31:0] t,
                           input logic [7:0] h, input logic [15:0] r);
        ld_valid = 1'b1; ld_idx = 3'(idx); ld_vector = v; ld_tag = t;
        ld_handle = h; ld_regval = r;
        step();
        ld_valid = 1'b0;
    endtask

    // Pulse the done of the engine that serves level idx (or the other one).
    task automatic pulse_done(input int idx, input bit wrong);
        if ((idx == 4) ^ wrong) dma_done = 1'b1; else intr_done = 1'b1;
        step();
        dma_done = 1'b0; intr_done = 1'b0;
    endtask

    function automatic logic [15:0] vec_of(input int i); return 16'h1230 + 16'(i); endfunction
    function automatic logic [31:0] tag_of(input int i); return 32'hC0DE_0000 + 32'(i * 17); endfunction

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R5: every grant pattern passes straight through when nothing is open.
        for (int p = 0; p < 32; p++) begin
            gnt_in = 5'(p);
            step();
            chk("R5 idle pass-through", 64'(gnt_out), 64'(p));
        end
        gnt_in = '0;
        step();
        chk("R5 pass-through release", 64'(gnt_out), 64'h0);

        // Per-level walk: load, duplicate, grant, release, wrong done, right done, reload.
        for (int i = 0; i < NLVL; i++) begin
            do_load(i, vec_of(i), tag_of(i), 8'(8'h40 + i), 16'(16'hBEE0 + i));
            chk("R1 R2 request bit", 64'(req_out), 64'(1 << i));
            chk("R3 reg write strobe", 64'(reg_wr_en), 64'(i < 4));
            if (i < 4) begin
                chk("R3 reg write handle", 64'(reg_wr_handle), 64'(8'h40 + i));
                chk("R3 reg write value", 64'(reg_wr_value), 64'(16'hBEE0 + i));
            end
            chk("R4 no error on idle load", 64'(ld_err), 64'h0);
            step();
            chk("R3 reg write single pulse", 64'(reg_wr_en), 64'h0);
            chk("R2 request held", 64'(req_out), 64'(1 << i));

            do_load(i, 16'hFFFF, 32'hDEAD_BEEF, 8'hFF, 16'hFFFF);
            chk("R4 error on pending level", 64'(ld_err), 64'h1);
            chk("R4 request unchanged", 64'(req_out), 64'(1 << i));

            gnt_in = 5'h1F;
            step();
            chk("R6 request cleared", 64'(req_out), 64'h0);
            chk("R6 sack raised", 64'(sack), 64'h1);
            chk("R6 intr start", 64'(intr_start), 64'(i < 4));
            chk("R6 dma start", 64'(dma_start), 64'(i == 4));
            chk("R6 start level", 64'(start_level), 64'(i));
            if (i < 4) chk("R6 vector", 64'(intr_vector), 64'(vec_of(i)));
            chk("R6 R5 grant not passed on taken level", 64'(gnt_out), 64'(5'h1F & ~(5'(1) << i)));
            step();
            chk("R6 start single pulse", 64'({intr_start, dma_start}), 64'h0);
            chk("R8 sack held with grant", 64'(sack), 64'h1);
            chk("R8 held level still blocked", 64'(gnt_out), 64'(5'h1F & ~(5'(1) << i)));
            gnt_in = '0;
            step();
            chk("R8 sack released", 64'(sack), 64'h0);
            chk("R5 grant outputs released", 64'(gnt_out), 64'h0);

            do_load(i, vec_of(i), tag_of(i), 8'h0, 16'h0);
            chk("R4 R10 error on busy level", 64'(ld_err), 64'h1);
            pulse_done(i, 1'b1);
            chk("R10 other engine done ignored", 64'(done_valid), 64'h0);
            do_load(i, vec_of(i), tag_of(i), 8'h0, 16'h0);
            chk("R10 still busy after wrong done", 64'(ld_err), 64'h1);
            pulse_done(i, 1'b0);
            chk("R10 done reported", 64'(done_valid), 64'h1);
            chk("R10 done tag", 64'(done_tag), 64'(tag_of(i)));
            step();
            chk("R10 done single pulse", 64'(done_valid), 64'h0);
            do_load(i, vec_of(i), tag_of(i), 8'h0, 16'h0);
            chk("R10 reload accepted", 64'(ld_err), 64'h0);
            chk("R10 reload raises request", 64'(req_out), 64'(1 << i));
            do_reset();
        end

        // R7: fill all levels and grant everything repeatedly.
        for (int i = 0; i < NLVL; i++)
            do_load(i, vec_of(i), 32'h5000_0000 | 32'(i), 8'h0, 16'h0);
        chk("R1 all requests", 64'(req_out), 64'h1F);
        for (int k = NLVL - 1; k >= 0; k--) begin
            gnt_in = 5'h1F;
            step();
            chk("R7 priority winner", 64'(start_level), 64'(k));
            chk("R7 dma start on top level", 64'(dma_start), 64'(k == 4));
            chk("R7 losers stay pending", 64'(req_out), 64'((1 << k) - 1));
            chk("R7 only finished levels pass", 64'(gnt_out), 64'(5'h1F & ~5'((2 << k) - 1)));
            gnt_in = '0;
            step();
            pulse_done(k, 1'b0);
            chk("R7 R10 tag in order", 64'(done_tag), 64'(32'h5000_0000 | 32'(k)));
        end

        // R9: a grant during an outstanding transfer is neither taken nor passed.
        do_reset();
        do_load(0, vec_of(0), tag_of(0), 8'h0, 16'h0);
        do_load(1, vec_of(1), tag_of(1), 8'h0, 16'h0);
        gnt_in = 5'h02;
        step();
        chk("R6 level 5 taken", 64'(start_level), 64'h1);
        gnt_in = '0;
        step();
        gnt_in = 5'h01;
        step();
        chk("R9 pending kept during transfer", 64'(req_out), 64'h01);
        chk("R9 no start during transfer", 64'({intr_start, dma_start}), 64'h0);
        chk("R9 grant not passed", 64'(gnt_out), 64'h0);
        chk("R9 no sack", 64'(sack), 64'h0);
        intr_done = 1'b1;
        step();
        intr_done = 1'b0;
        chk("R10 done of level 5", 64'(done_tag), 64'(tag_of(1)));
        chk("R9 no start on done edge", 64'(intr_start), 64'h0);
        step();
        chk("R9 grant taken after done", 64'(intr_start), 64'h1);
        chk("R9 level 4 started", 64'(start_level), 64'h0);
        chk("R9 request cleared", 64'(req_out), 64'h0);
        gnt_in = '0;
        step();

        // R4: out-of-range indices are rejected.
        do_reset();
        for (int x = 5; x < 8; x++) begin
            do_load(x, 16'h0, 32'h0, 8'h0, 16'h0);
            chk("R4 out-of-range rejected", 64'(ld_err), 64'h1);
            chk("R4 no request raised", 64'(req_out), 64'h0);
        end

        // R11: reset in the middle of a transfer.
        do_load(2, vec_of(2), tag_of(2), 8'h0, 16'h0);
        do_load(4, vec_of(4), tag_of(4), 8'h0, 16'h0);
        gnt_in = 5'h13;
        step();
        chk("R11 setup sack", 64'(sack), 64'h1);
        do_reset();
        do_load(4, vec_of(4), tag_of(4), 8'h0, 16'h0);
        chk("R11 level idle after reset", 64'(ld_err), 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule